// File: doc/BRIEF.md
# Memory-Indirect Load Execution Unit

This block executes one load instruction at a time for a 32-bit register-based datapath whose physical memory is reached through 26 address lines. It takes a decoded 32-bit instruction word. From the opcode it chooses one of two modes. In displacement mode it forms an effective address from a base register plus a sign-extended 16-bit offset, reads one word, and writes that word to the destination register. In memory-indirect mode the word read at the effective address is used as a pointer. A second, dependent read fetches the final data word from that pointer before writeback.

The unit reads a 32-entry register file through a read-address/read-data pair. It writes the register file through a write strobe. It reaches a single-port, word-organised memory through a request held until a one-cycle valid pulse returns the read data. A control FSM (idle, address calculation, first access, second access, writeback) drives a small datapath through a struct of strobes.

Top module: `ind_load_unit`

## Requirements
- R1: The instruction word is split as opcode [31:26], base register [25:21], destination register [20:16] and signed offset [15:0]. Opcode 6'h23 selects a displacement load and opcode 6'h33 selects an indirect load. Any other opcode is ignored: busy stays low, no memory request is made and nothing is written.
- R2: The effective address is the 32-bit sum of the base register value and the sign-extended offset. The memory address port carries the low 26 bits of that byte address.
- R3: Register 0 used as a base always counts as zero, whatever the register file returns. With base 0, offset 16'h8000 wraps to byte address 32'hFFFF8000, so the port shows 26'h3FF8000.
- R4: A displacement load makes exactly one memory request, at the effective address. It then writes the returned word to the destination register in the cycle after the valid pulse.
- R5: An indirect load makes exactly two requests: first at the effective address, then at the pointer word returned by the first. It writes the word returned by the second request to the destination register.
- R6: A memory request and its address stay unchanged until memValid is seen. Read data is taken in the valid cycle.
- R7: busy is high from the cycle after an instruction is accepted until writeback ends. An instruction presented while busy is ignored.
- R8: A load whose destination is register 0 performs its memory requests but never raises rfWrEn.
- R9: An effective address whose bits [1:0] are not zero causes a one-cycle misaligned pulse in the cycle after the address calculation. There is no memory request and no write.
- R10: In indirect mode, a pointer whose bits [1:0] are not zero causes a one-cycle misaligned pulse in the cycle after the first valid pulse. There is no second request and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word presented |
| instrWord | input | 32 | Decoded load instruction |
| busy | output | 1 | Unit is executing an instruction |
| misaligned | output | 1 | One-cycle abort flag for an unaligned address or pointer |
| rfRdAddr | output | 5 | Register file read index (base register) |
| rfRdData | input | 32 | Register file read data |
| rfWrEn | output | 1 | Register file write strobe |
| rfWrAddr | output | 5 | Register file write index |
| rfWrData | output | 32 | Register file write data |
| memReq | output | 1 | Memory read request, held until valid |
| memAddr | output | 26 | Byte address to memory |
| memValid | input | 1 | Memory read data valid pulse |
| memRdata | input | 32 | Memory read data |

## Verification
The hardest case to reach from the ports is an indirect load that aborts after its first access. The pointer is known only inside the unit, and nothing may follow the abort. The bench stores an unaligned pointer word in its memory model at an aligned effective address. It then confirms that exactly one request was logged, that the flag pulsed, and that no write strobe appeared. The busy-ignore case raises the memory latency, so that a second instruction presented while busy falls well inside the first one's access window.

// File: rtl/ilu_pkg.sv
package ilu_pkg;
  localparam int DATA_W   = 32;
  localparam int PADDR_W  = 26;
  localparam int REG_AW   = 5;
  localparam int IMM_W    = 16;
  localparam int OPC_W    = 6;
  localparam logic [OPC_W-1:0] OP_DISP = 6'h23;
  localparam logic [OPC_W-1:0] OP_IND  = 6'h33;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CALC, ST_MEM1, ST_MEM2, ST_WB
  } ldState_t;

  typedef struct packed {
    logic latchInstr;
    logic loadEa;
    logic loadPtr;
    logic captureData;
  } ctrlStrobes_t;
endpackage

// File: rtl/ilu_ctrl.sv
module ilu_ctrl
  import ilu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrValid,
  input  logic [OPC_W-1:0] opcode,
  input  logic             memValid,
  input  logic             eaMisal,
  input  logic             ptrMisal,
  input  logic             rdZero,
  output ctrlStrobes_t     strb,
  output logic             busy,
  output logic             memReq,
  output logic             rfWrEn,
  output logic             misaligned
);
  ldState_t state, nxt;
  logic indQ;
  logic misQ;
  logic misNext;
  logic opKnown;

  assign opKnown = (opcode == OP_DISP) || (opcode == OP_IND);

  always_comb begin
    nxt     = state;
    strb    = '0;
    misNext = 1'b0;
    unique case (state)
      ST_IDLE: if (instrValid && opKnown) begin
        strb.latchInstr = 1'b1;
        nxt = ST_CALC;
      end
      ST_CALC: if (eaMisal) begin
        misNext = 1'b1;
        nxt = ST_IDLE;
      end else begin
        strb.loadEa = 1'b1;
        nxt = ST_MEM1;
      end
      ST_MEM1: if (memValid) begin
        if (indQ) begin
          if (ptrMisal) begin
            misNext = 1'b1;
            nxt = ST_IDLE;
          end else begin
            strb.loadPtr = 1'b1;
            nxt = ST_MEM2;
          end
        end else begin
          strb.captureData = 1'b1;
          nxt = ST_WB;
        end
      end
      ST_MEM2: if (memValid) begin
        strb.captureData = 1'b1;
        nxt = ST_WB;
      end
      ST_WB: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      indQ  <= 1'b0;
      misQ  <= 1'b0;
    end else begin
      state <= nxt;
      misQ  <= misNext;
      if (strb.latchInstr) indQ <= (opcode == OP_IND);
    end
  end

  assign busy       = (state != ST_IDLE);
  assign memReq     = (state == ST_MEM1) || (state == ST_MEM2);
  assign rfWrEn     = (state == ST_WB) && !rdZero;
  assign misaligned = misQ;
endmodule

// File: rtl/ilu_datapath.sv
module ilu_datapath
  import ilu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [DATA_W-1:0]  instrWord,
  input  logic [DATA_W-1:0]  rfRdData,
  input  logic [DATA_W-1:0]  memRdata,
  output logic [REG_AW-1:0]  rfRdAddr,
  output logic [REG_AW-1:0]  rfWrAddr,
  output logic [DATA_W-1:0]  rfWrData,
  output logic [PADDR_W-1:0] memAddr,
  output logic               eaMisal,
  output logic               ptrMisal,
  output logic               rdZero
);
  localparam int RS_LSB = IMM_W + REG_AW;
  localparam int RD_LSB = IMM_W;

  logic [DATA_W-1:0] instrQ, addrQ, dataQ, baseVal, offsetExt, effAddr;
  logic [REG_AW-1:0] rsIdx, rdIdx;
  logic [IMM_W-1:0]  immVal;

  assign rsIdx     = instrQ[RS_LSB +: REG_AW];
  assign rdIdx     = instrQ[RD_LSB +: REG_AW];
  assign immVal    = instrQ[IMM_W-1:0];
  assign baseVal   = (rsIdx == '0) ? '0 : rfRdData;
  assign offsetExt = {{(DATA_W-IMM_W){immVal[IMM_W-1]}}, immVal};
  assign effAddr   = baseVal + offsetExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instrQ <= '0;
      addrQ  <= '0;
      dataQ  <= '0;
    end else begin
      if (strb.latchInstr)  instrQ <= instrWord;
      if (strb.loadEa)      addrQ  <= effAddr;
      else if (strb.loadPtr) addrQ <= memRdata;
      if (strb.captureData) dataQ  <= memRdata;
    end
  end

  assign rfRdAddr = rsIdx;
  assign rfWrAddr = rdIdx;
  assign rfWrData = dataQ;
  assign memAddr  = addrQ[PADDR_W-1:0];
  assign eaMisal  = (effAddr[1:0] != 2'b00);
  assign ptrMisal = (memRdata[1:0] != 2'b00);
  assign rdZero   = (rdIdx == '0);
endmodule

// File: rtl/ind_load_unit.sv
module ind_load_unit
  import ilu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [DATA_W-1:0]  instrWord,
  output logic               busy,
  output logic               misaligned,
  output logic [REG_AW-1:0]  rfRdAddr,
  input  logic [DATA_W-1:0]  rfRdData,
  output logic               rfWrEn,
  output logic [REG_AW-1:0]  rfWrAddr,
  output logic [DATA_W-1:0]  rfWrData,
  output logic               memReq,
  output logic [PADDR_W-1:0] memAddr,
  input  logic               memValid,
  input  logic [DATA_W-1:0]  memRdata
);
  ctrlStrobes_t strb;
  logic eaMisal, ptrMisal, rdZero;

  ilu_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid),
    .opcode(instrWord[DATA_W-1 -: OPC_W]), .memValid(memValid),
    .eaMisal(eaMisal), .ptrMisal(ptrMisal), .rdZero(rdZero),
    .strb(strb), .busy(busy), .memReq(memReq), .rfWrEn(rfWrEn),
    .misaligned(misaligned)
  );

  ilu_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .instrWord(instrWord),
    .rfRdData(rfRdData), .memRdata(memRdata), .rfRdAddr(rfRdAddr),
    .rfWrAddr(rfWrAddr), .rfWrData(rfWrData), .memAddr(memAddr),
    .eaMisal(eaMisal), .ptrMisal(ptrMisal), .rdZero(rdZero)
  );
endmodule

// File: rtl/ind_load_unit_chk.sv
module ind_load_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        misaligned,
  input logic        rfWrEn,
  input logic [4:0]  rfWrAddr,
  input logic        memReq,
  input logic [25:0] memAddr,
  input logic        memValid
);
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memAddr)));

  a_r7_req_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  a_r8_no_write_r0: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (rfWrAddr != 5'd0));

  a_r9_flag_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |=> !misaligned);

  a_r10_flag_no_write: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> (!rfWrEn && !memReq));

  a_r4_write_after_valid: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> $past(memValid));

  a_r2_word_addr: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00));
endmodule

bind ind_load_unit ind_load_unit_chk chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .misaligned(misaligned),
  .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .memReq(memReq),
  .memAddr(memAddr), .memValid(memValid)
);

// File: tb/ind_load_unit_tb_top.sv
module ind_load_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        busy, misaligned, rfWrEn, memReq;
  logic [4:0]  rfRdAddr, rfWrAddr;
  logic [31:0] rfRdData, rfWrData;
  logic [25:0] memAddr;
  logic        memValid = 1'b0;
  logic [31:0] memRdata = '0;

  logic [31:0] regs [32];
  logic [31:0] mem [256];
  int lat = 0;
  int waitCnt = 0;
  int reqCount = 0, wrCount = 0, misCount = 0;
  logic [25:0] reqLog [4];
  logic [4:0]  lastWrAddr;
  logic [31:0] lastWrData;
  int checks = 0, errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  assign rfRdData = regs[rfRdAddr];

  ind_load_unit dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .busy(busy), .misaligned(misaligned), .rfRdAddr(rfRdAddr),
    .rfRdData(rfRdData), .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr),
    .rfWrData(rfWrData), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (memReq && !memValid && waitCnt >= lat) begin
      memValid <= 1'b1;
      memRdata <= mem[memAddr[9:2]];
      if (reqCount < 4) reqLog[reqCount] <= memAddr;
      reqCount <= reqCount + 1;
      waitCnt  <= 0;
    end else begin
      memValid <= 1'b0;
      if (memReq && !memValid) waitCnt <= waitCnt + 1;
    end
    if (rfWrEn) begin
      wrCount    <= wrCount + 1;
      lastWrAddr <= rfWrAddr;
      lastWrData <= rfWrData;
    end
    if (misaligned) misCount <= misCount + 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                     input logic [4:0] rd, input logic [15:0] imm);
    return {op, rs, rd, imm};
  endfunction

  task automatic clearLogs();
    @(negedge clk);
    reqCount = 0; wrCount = 0; misCount = 0;
  endtask

  task automatic run(input logic [31:0] w);
    clearLogs();
    instrValid = 1'b1; instrWord = w;
    @(negedge clk);
    instrValid = 1'b0;
    for (int i = 0; i < 60 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic tReset();
    check(!busy && !memReq && !rfWrEn && !misaligned, "reset R7", {busy, memReq, rfWrEn, misaligned}, 0);
  endtask

  task automatic tDisp(input logic [4:0] rs, input logic [31:0] base, input logic [15:0] imm,
                       input logic [4:0] rd, input logic [25:0] expAddr, input logic [31:0] data,
                       input string tag);
    regs[rs] = base;
    mem[expAddr[9:2]] = data;
    run(mk(6'h23, rs, rd, imm));
    check(reqCount == 1, {tag, " R4 request count"}, reqCount, 1);
    check(reqLog[0] == expAddr, {tag, " R2 address"}, {6'd0, reqLog[0]}, {6'd0, expAddr});
    check(wrCount == 1 && lastWrAddr == rd && lastWrData == data, {tag, " R4 write"}, lastWrData, data);
  endtask

  task automatic tZeroBase();
    regs[0] = 32'hDEAD0000;
    tDisp(5'd0, 32'hDEAD0000, 16'h0040, 5'd9, 26'h0000040, 32'hA5A50040, "R3 zero base");
    tDisp(5'd0, 32'hDEAD0000, 16'h8000, 5'd10, 26'h3FF8000, 32'h0BADF00D, "R3 wrap");
  endtask

  task automatic tIndirect(input logic [4:0] rd, input int l, input string tag);
    lat = l;
    regs[3] = 32'h80;
    mem[32'h80 >> 2]  = 32'h200;
    mem[32'h200 >> 2] = 32'h12345678;
    run(mk(6'h33, 5'd3, rd, 16'h0));
    check(reqCount == 2, {tag, " R5 request count"}, reqCount, 2);
    check(reqLog[0] == 26'h80 && reqLog[1] == 26'h200, {tag, " R5 addresses"},
          {6'd0, reqLog[1]}, 32'h200);
    if (rd == 0)
      check(wrCount == 0, {tag, " R8 no write to r0"}, wrCount, 0);
    else
      check(wrCount == 1 && lastWrData == 32'h12345678 && lastWrAddr == rd,
            {tag, " R5 write"}, lastWrData, 32'h12345678);
    lat = 0;
  endtask

  task automatic tBadOpcode();
    clearLogs();
    instrValid = 1'b1; instrWord = mk(6'h2B, 5'd3, 5'd4, 16'h0);
    @(negedge clk);
    check(!busy, "R1 unknown opcode busy", busy, 0);
    instrValid = 1'b0;
    repeat (6) @(negedge clk);
    check(reqCount == 0 && wrCount == 0, "R1 unknown opcode activity", reqCount + wrCount, 0);
  endtask

  task automatic tMisalEa();
    regs[4] = 32'h102;
    run(mk(6'h23, 5'd4, 5'd5, 16'h0));
    check(misCount == 1, "R9 flag pulses", misCount, 1);
    check(reqCount == 0 && wrCount == 0, "R9 no access no write", reqCount + wrCount, 0);
  endtask

  task automatic tMisalPtr();
    regs[3] = 32'h80;
    mem[32'h80 >> 2] = 32'h203;
    run(mk(6'h33, 5'd3, 5'd6, 16'h0));
    check(misCount == 1, "R10 flag pulses", misCount, 1);
    check(reqCount == 1 && wrCount == 0, "R10 single access no write", reqCount * 16 + wrCount, 16);
  endtask

  task automatic tBusyIgnore();
    lat = 4;
    regs[5] = 32'h100;
    mem[32'h100 >> 2] = 32'h5555AAAA;
    clearLogs();
    instrValid = 1'b1; instrWord = mk(6'h23, 5'd5, 5'd7, 16'h0);
    @(negedge clk);
    check(busy, "R7 busy after accept", busy, 1);
    instrWord = mk(6'h23, 5'd5, 5'd8, 16'h0);
    repeat (2) @(negedge clk);
    instrValid = 1'b0;
    check(busy && memReq, "R6 request pending", {busy, memReq}, 2'b11);
    for (int i = 0; i < 60 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(wrCount == 1 && lastWrAddr == 5'd7, "R7 second word ignored", lastWrAddr, 7);
    check(reqCount == 1, "R6 one request under latency", reqCount, 1);
    lat = 0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 32'h0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tDisp(5'd5, 32'h100, 16'h0010, 5'd7, 26'h0000110, 32'hCAFE0001, "R1 R2 basic");
    tDisp(5'd6, 32'h120, 16'hFFF8, 5'd8, 26'h0000118, 32'hCAFE0002, "R2 negative offset");
    tDisp(5'd7, 32'hFC000300, 16'h0004, 5'd11, 26'h0000304, 32'hCAFE0003, "R2 truncation");
    tZeroBase();
    tIndirect(5'd12, 0, "indirect fast");
    tIndirect(5'd13, 3, "R6 indirect slow");
    tIndirect(5'd0, 1, "indirect to r0");
    tBadOpcode();
    tMisalEa();
    tMisalPtr();
    tBusyIgnore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule